// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects a configurable number of interrupt lines and folds them into one registered request towards a processor. Each line is fixed at build time as either edge-triggered or level-triggered. A small register set lets software read and inject pending state, mask individual lines, clear latched edges and find out which line to serve first. The lowest-numbered line that is both pending and enabled always wins.

A two-bit master control register governs the block. Its low bit lets the request reach the processor. Its high bit hands the pending bits over to the hardware lines. Before that handover, software can write pending bits directly to raise test interrupts, and the hardware lines are ignored. Once the handover is made, it holds until reset, and direct pending writes have no effect.

The register port is a plain synchronous write strobe with address and data. Reads are combinational from the address.

Top module: `irq_hub`

## Requirements
- R1: After reset, the pending, enable and master registers read zero, the request output is low, and the vector register reads all ones.
- R2: In hardware mode, an edge-type line sets its pending bit at the first clock edge where it is sampled high after being sampled low. The bit then stays set while the line falls, until it is acknowledged.
- R3: In hardware mode, a level-type line's pending bit equals the line value sampled at the previous clock edge. An acknowledge written while the line is high leaves the bit set.
- R4: Writing the acknowledge register (address 2) clears each edge-type pending bit, and in software mode each pending bit, whose data bit is 1. A rising edge in the same cycle keeps the bit set. Address 2 reads zero.
- R5: The enable register (address 1, bit i for line i) is read/write. A pending line with its enable bit at 0 affects neither the vector nor the request output.
- R6: The master register (address 3) has two bits: bit 0 is the request enable and bit 1 is the hardware mode. Bit 0 follows each write. Bit 1 is set by writing 1 and is cleared only by reset.
- R7: In software mode (master bit 1 at 0), a write to the pending register (address 0) ORs its data into the pending bits, and the lines have no effect. In hardware mode, writes to address 0 are ignored.
- R8: The vector register (address 4) reads the lowest index i whose pending and enable bits are both 1. It reads all ones when no such i exists.
- R9: The request output is high in the cycle after a cycle in which master bit 0 was 1 and at least one line was both pending and enabled, and low otherwise.
- R10: Register bits at positions at or above the line count read zero, and addresses 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_i | input | NSRC | Interrupt lines, bit i is line i |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | DW | Register write data |
| bus_rdata_o | output | DW | Register read data for bus_addr_i |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The case that is hardest to reach is the interplay across the one-way switch into hardware mode. Software-injected pending bits, their acknowledges and priority decisions must all be covered before the switch. After it, ignored pending writes, acknowledges against a still-high level line, and edges that coincide with acknowledges must be covered. The bench therefore runs a long random phase with the hardware-mode bit forced to zero and then deliberately throws the switch. Directed edge, level and acknowledge sequences follow, and then a second random phase. A bench model compares every register read and the request output on every cycle.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_PEND = 3'd0,
    RA_ENAB = 3'd1,
    RA_ACK  = 3'd2,
    RA_MSTR = 3'd3,
    RA_VECT = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/irq_hub_rst_sync.sv
module irq_hub_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  assign sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/irq_hub_cell.sv
module irq_hub_cell #(
  parameter bit IS_EDGE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hw_en_i,
  input  logic irq_i,
  input  logic sw_set_i,
  input  logic ack_i,
  output logic pend_o
);
  logic in_q;
  logic pend_q;
  logic pend_d;
  logic rise;

  assign rise = irq_i & ~in_q;

  always_comb begin
    pend_d = pend_q;
    if (!hw_en_i) begin
      pend_d = (pend_q & ~ack_i) | sw_set_i;
    end else if (IS_EDGE) begin
      pend_d = (pend_q & ~ack_i) | rise;
    end else begin
      pend_d = irq_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      in_q   <= irq_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  // R7
  hw_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_en_i && !pend_q && !irq_i) |=> !pend_q);

  if (IS_EDGE) begin : g_edge_chk
    // R2
    edge_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hw_en_i && pend_q && !ack_i) |=> pend_q);
  end else begin : g_level_chk
    // R3
    level_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hw_en_i |=> (pend_q == $past(irq_i)));
  end
endmodule

// File: rtl/irq_hub_prio.sv
module irq_hub_prio #(
  parameter int unsigned NSRC = 12,
  parameter int unsigned DW   = 16
) (
  input  logic [NSRC-1:0] act_i,
  output logic [DW-1:0]   vec_o,
  output logic            any_o
);
  localparam int unsigned IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [IW-1:0] idx;

  always_comb begin
    idx   = '0;
    any_o = 1'b0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (act_i[i]) begin
        idx   = IW'(i);
        any_o = 1'b1;
      end
    end
  end

  assign vec_o = any_o ? DW'(idx) : '1;

  // R8
  always_comb begin
    prio_lowest_chk: assert (!any_o ||
      (act_i[idx] && ((act_i & ((NSRC'(1) << idx) - NSRC'(1))) == '0)));
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int unsigned     DW        = 16,
  parameter int unsigned     NSRC      = 12,
  parameter logic [NSRC-1:0] EDGE_MASK = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   irq_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic              irq_o
);
  logic            rst_n;
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] act;
  logic [NSRC-1:0] sw_set;
  logic [NSRC-1:0] ack;
  logic [NSRC-1:0] en_q, en_d;
  logic [1:0]      mst_q, mst_d;
  logic            irq_q, irq_d;
  logic            en_we, mst_we;
  logic            any;
  logic [DW-1:0]   vec;
  logic            unused_wdata;

  assign unused_wdata = ^bus_wdata_i;

  irq_hub_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  // write decode
  assign en_we  = bus_wr_i && (bus_addr_i == RA_ENAB);
  assign mst_we = bus_wr_i && (bus_addr_i == RA_MSTR);
  assign sw_set = (bus_wr_i && (bus_addr_i == RA_PEND)) ? bus_wdata_i[NSRC-1:0] : '0;
  assign ack    = (bus_wr_i && (bus_addr_i == RA_ACK))  ? bus_wdata_i[NSRC-1:0] : '0;

  for (genvar g = 0; g < NSRC; g++) begin : g_cell
    irq_hub_cell #(
      .IS_EDGE (EDGE_MASK[g])
    ) u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_n),
      .hw_en_i  (mst_q[1]),
      .irq_i    (irq_i[g]),
      .sw_set_i (sw_set[g]),
      .ack_i    (ack[g]),
      .pend_o   (pend[g])
    );
  end

  assign act = pend & en_q;

  irq_hub_prio #(
    .NSRC (NSRC),
    .DW   (DW)
  ) u_prio (
    .act_i (act),
    .vec_o (vec),
    .any_o (any)
  );

  // next state
  always_comb begin
    en_d  = bus_wdata_i[NSRC-1:0];
    mst_d = {mst_q[1] | bus_wdata_i[1], bus_wdata_i[0]};
    irq_d = mst_q[0] & any;
  end

  // registers with explicit enables
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      mst_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (en_we)  en_q  <= en_d;
      if (mst_we) mst_q <= mst_d;
      irq_q <= irq_d;
    end
  end

  // read mux
  always_comb begin
    case (bus_addr_i)
      RA_PEND: bus_rdata_o = DW'(pend);
      RA_ENAB: bus_rdata_o = DW'(en_q);
      RA_MSTR: bus_rdata_o = DW'(mst_q);
      RA_VECT: bus_rdata_o = vec;
      default: bus_rdata_o = '0;
    endcase
  end

  assign irq_o = irq_q;

  // R6
  hw_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    mst_q[1] |=> mst_q[1]);

  // R9
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(irq_q) |-> $past(mst_q[0]));

  // R9
  irq_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !mst_q[0] |=> !irq_q);
endmodule

// File: tb/irq_hub_bench.sv
`timescale 1ns/1ps
module irq_hub_bench;
  localparam int DW = 16;
  localparam int NS = 12;
  localparam logic [NS-1:0] EM = 12'h555; // even lines edge, odd lines level

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] irq_in;
  logic          wr;
  logic [2:0]    addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          irq;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  irq_hub #(.DW(DW), .NSRC(NS), .EDGE_MASK(EM)) u_irq_hub (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .irq_i       (irq_in),
    .bus_wr_i    (wr),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  // bench model built from the requirements
  logic [NS-1:0] m_pend, m_en, m_prev;
  logic [1:0]    m_mst;
  logic          m_irq;

  function automatic logic [NS-1:0] f_next(input logic [NS-1:0] p, input logic [NS-1:0] prv,
                                           input logic [NS-1:0] in, input logic hw,
                                           input logic [NS-1:0] a, input logic [NS-1:0] s);
    logic [NS-1:0] n;
    for (int i = 0; i < NS; i++) begin
      if (!hw)        n[i] = (p[i] & ~a[i]) | s[i];
      else if (EM[i]) n[i] = (p[i] & ~a[i]) | (in[i] & ~prv[i]);
      else            n[i] = in[i];
    end
    return n;
  endfunction

  function automatic logic [DW-1:0] f_vec(input logic [NS-1:0] act);
    for (int i = 0; i < NS; i++) if (act[i]) return DW'(i);
    return '1;
  endfunction

  function automatic logic [DW-1:0] f_read(input logic [2:0] a);
    case (a)
      3'd0:    return DW'(m_pend);
      3'd1:    return DW'(m_en);
      3'd3:    return DW'(m_mst);
      3'd4:    return f_vec(m_pend & m_en);
      default: return '0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend <= '0; m_en <= '0; m_prev <= '0; m_mst <= '0; m_irq <= 1'b0;
    end else begin
      m_pend <= f_next(m_pend, m_prev, irq_in, m_mst[1],
                       (wr && addr == 3'd2) ? wdata[NS-1:0] : '0,
                       (wr && addr == 3'd0) ? wdata[NS-1:0] : '0);
      m_prev <= irq_in;
      m_irq  <= m_mst[0] & (|(m_pend & m_en));
      if (wr && addr == 3'd1) m_en <= wdata[NS-1:0];
      if (wr && addr == 3'd3) m_mst <= {m_mst[1] | wdata[1], wdata[0]};
    end
  end

  task automatic check(input string tag);
    string t;
    t = tag;
    if (t == "") begin
      case (addr)
        3'd0:    t = "R7";
        3'd1:    t = "R5";
        3'd3:    t = "R6";
        3'd4:    t = "R8";
        default: t = "R10";
      endcase
    end
    n_chk++;
    if (rdata !== f_read(addr)) begin
      n_err++;
      $display("FAIL %s: read addr %0d got %h expected %h", t, addr, rdata, f_read(addr));
    end
    n_chk++;
    if (irq !== m_irq) begin
      n_err++;
      $display("FAIL R9 (%s): irq_o got %b expected %b", t, irq, m_irq);
    end
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic tick(input logic w, input logic [2:0] a, input logic [DW-1:0] d,
                      input logic [NS-1:0] i, input string tag);
    wr = w; addr = a; wdata = d; irq_in = i;
    @(negedge clk);
    check(tag);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL R1: watchdog got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240917));
    rst_n = 1'b0; wr = 1'b0; addr = '0; wdata = '0; irq_in = '0;
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state of every register
    for (int a = 0; a < 8; a++) tick(0, 3'(a), '0, '0, "R1");

    // R7 software mode: lines are ignored
    tick(0, 3'd0, '0, '1, "R7");
    tick(0, 3'd0, '0, '1, "R7");
    tick(0, 3'd0, '0, '0, "R7");
    // R7 injected pending bits 2 and 5
    tick(1, 3'd0, 16'h0024, '0, "R7");
    // R5 only line 5 enabled
    tick(1, 3'd1, 16'h0020, '0, "R5");
    tick(0, 3'd4, '0, '0, "R8");
    // R8 lowest enabled index wins
    tick(1, 3'd1, 16'hFFFF, '0, "R10");
    tick(0, 3'd4, '0, '0, "R8");
    // R9 request enable
    tick(1, 3'd3, 16'h0001, '0, "R9");
    tick(0, 3'd3, '0, '0, "R9");
    // R4 acknowledge line 2
    tick(1, 3'd2, 16'h0004, '0, "R4");
    tick(0, 3'd4, '0, '0, "R4");
    // R6 request disable drops output
    tick(1, 3'd3, 16'h0000, '0, "R6");
    tick(0, 3'd0, '0, '0, "R6");

    // random software-mode phase (hardware-mode bit held at 0)
    for (int n = 0; n < 400; n++) begin
      logic [2:0]    ra;
      logic [DW-1:0] rd;
      ra = 3'($urandom % 8);
      rd = DW'($urandom);
      if (ra == 3'd3) rd[1] = 1'b0;
      tick(1'($urandom % 2), ra, rd, NS'($urandom), "");
    end

    // R6 switch to hardware mode
    tick(1, 3'd2, 16'hFFFF, '0, "R4");
    tick(1, 3'd3, 16'h0003, '0, "R6");
    tick(0, 3'd0, '0, '0, "R6");
    // R6 writing 0 to bit 1 does not clear it
    tick(1, 3'd3, 16'h0001, '0, "R6");
    tick(0, 3'd3, '0, '0, "R6");
    // R7 pending writes ignored in hardware mode
    tick(1, 3'd0, 16'h0FFF, '0, "R7");
    tick(0, 3'd0, '0, '0, "R7");
    tick(1, 3'd1, 16'h0FFF, '0, "R5");

    // R2 edge line 2: pulse, then bit holds
    tick(0, 3'd0, '0, 12'h004, "R2");
    tick(0, 3'd0, '0, 12'h000, "R2");
    tick(0, 3'd0, '0, 12'h000, "R2");
    tick(0, 3'd4, '0, 12'h000, "R8");
    // R4 acknowledge and a simultaneous new edge on line 4
    tick(1, 3'd2, 16'h0014, 12'h010, "R4");
    tick(0, 3'd0, '0, 12'h010, "R4");
    tick(1, 3'd2, 16'h0010, 12'h010, "R4");
    tick(0, 3'd0, '0, 12'h000, "R2");
    // R3 level line 3: follows, survives acknowledge while high
    tick(0, 3'd0, '0, 12'h008, "R3");
    tick(1, 3'd2, 16'h0008, 12'h008, "R3");
    tick(0, 3'd0, '0, 12'h008, "R3");
    tick(0, 3'd0, '0, 12'h000, "R3");
    tick(0, 3'd4, '0, 12'h000, "R8");
    tick(0, 3'd5, '0, 12'h000, "R10");

    // random hardware-mode phase
    for (int n = 0; n < 2000; n++) begin
      tick(1'($urandom % 3 == 0), 3'($urandom % 8), DW'($urandom), NS'($urandom), "");
    end

    finish_run();
  end
endmodule